// File: doc/BRIEF.md
# Synthesizer Two-Wire Control Slave

This block is the serial control port of a frequency synthesizer. A host processor talks to it over a two-wire I2C bus. The block oversamples both bus lines with its own system clock and cleans them up. It follows the framing of the telegram, checks the device address and pulls SDA low in every acknowledge slot that belongs to it. The block drives SDA only as an open-drain output: it either pulls the line low or releases it.

A write telegram carries data bytes in pairs. The top bit of the first byte of each pair picks the destination: a 0 selects the 16-bit divider ratio register and a 1 selects the 16-bit control register. The second byte of the pair fills the lower half of that register. The register changes only once both bytes of the pair have arrived. In a read telegram, the block returns the byte on its status input. It keeps returning fresh status bytes for as long as the host acknowledges them.

Top module: `pll_i2c_slave`

## Requirements
- R1: After reset, `sdaPullLow` is 0 and `divRatio` and `ctlWord` are both 0.
- R2: After a start condition, the block shifts in eight bits, MSB first, on SCL rising edges. If bits 7..1 equal `DEV_ADDR`, it pulls SDA low from the following SCL fall until the fall that ends the ninth clock. Bit 0 selects write (0) or read (1).
- R3: If the address does not match, the block does not acknowledge. It then leaves SDA and both registers untouched until the next start condition. After a stop condition, bus clocks that come without a new start are also ignored.
- R4: In a write, a data byte in the first position of a pair with bit 7 = 0 opens a divider pair. The second byte completes it, and `divRatio` becomes {first, second}.
- R5: A first-position byte with bit 7 = 1 opens a control pair. On the second byte, `ctlWord` becomes {first, second}.
- R6: Pair selection restarts with every third, fifth, … data byte, so one telegram may update both registers in either order.
- R7: A register does not change after the first byte of its pair. A pair left incomplete by a stop or start condition is discarded.
- R8: Every data byte of a matched write is acknowledged in its ninth clock.
- R9: In a read, the block puts `statusIn` on SDA MSB first, one bit per clock. SDA changes only while SCL is low.
- R10: If the host acknowledges a status byte, `statusIn` is sampled again and sent as the next byte. If the host does not acknowledge, SDA stays released until the next start condition.
- R11: A repeated start begins a new address phase and resets the bit and pair position.
- R12: A SCL pulse lasting one system clock does not count as a bus clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as received |
| sdaIn | input | 1 | Serial data line as received |
| statusIn | input | BYTE_W | Status byte returned in read telegrams |
| sdaPullLow | output | 1 | 1 pulls SDA low, 0 releases it |
| divRatio | output | 2*BYTE_W | Divider ratio register |
| ctlWord | output | 2*BYTE_W | Control register |

## Verification
The hardest state to reach from the ports is a half-received pair that is then cut off by a repeated start. The bench sends the first byte of a divider pair, issues a repeated start and then completes a control pair. It checks that the divider register keeps its old value. A one-clock SCL glitch is injected inside a data byte, at the point where an extra count would misalign every later bit. The test then confirms that the register receives the byte as sent. Status bytes sent back to back are checked with the status input changed between them, so a byte that is not sampled again shows up as a stale value.

// File: rtl/pll_i2c_pkg.sv
package pll_i2c_pkg;

  // Strobes from control to datapath, at most one action per cycle per field
  typedef struct packed {
    logic shiftIn;    // take one received bit
    logic holdLd;     // park first byte of a pair
    logic commitDiv;  // write divider pair
    logic commitCtl;  // write control pair
    logic loadTx;     // load status byte for transmission
    logic shiftTx;    // advance to next transmit bit
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK,
    ST_IGNORE
  } busState_t;

endpackage

// File: rtl/pll_i2c_line_filter.sv
module pll_i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic lvl,
  output logic rise,
  output logic fall
);
  localparam int ONES_W = $clog2(FILT_TAPS + 1);
  localparam logic [ONES_W-1:0] HALF = ONES_W'(FILT_TAPS / 2);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [FILT_TAPS-1:0]   taps;
  logic [ONES_W-1:0]      ones;
  logic                   prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '1;
      taps    <= '1;
      lvl     <= 1'b1;
      prevLvl <= 1'b1;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], rawIn};
      taps    <= {taps[FILT_TAPS-2:0], syncQ[SYNC_STAGES-1]};
      lvl     <= (ones > HALF);
      prevLvl <= lvl;
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < FILT_TAPS; i++) ones = ones + ONES_W'(taps[i]);
  end

  assign rise = lvl & ~prevLvl;
  assign fall = ~lvl & prevLvl;

endmodule

// File: rtl/pll_i2c_datapath.sv
module pll_i2c_datapath
  import pll_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3,
  parameter int BYTE_W      = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic [BYTE_W-1:0]     statusIn,
  input  dpStrobe_t             strobe,
  output logic                  sclLvl,
  output logic                  sdaLvl,
  output logic                  sclRise,
  output logic                  sclFall,
  output logic                  startDet,
  output logic                  stopDet,
  output logic [BYTE_W-1:0]     rxNext,
  output logic                  txBit,
  output logic [2*BYTE_W-1:0]   divRatio,
  output logic [2*BYTE_W-1:0]   ctlWord
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] rawLines, lineLvl, lineRise, lineFall;
  logic [BYTE_W-1:0] rxShift, holdByte, txShift;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < NLINES; g++) begin : gLine
    pll_i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_TAPS  (FILT_TAPS)
    ) filt_i (
      .clk  (clk),
      .rstN (rstN),
      .rawIn(rawLines[g]),
      .lvl  (lineLvl[g]),
      .rise (lineRise[g]),
      .fall (lineFall[g])
    );
  end

  assign sclLvl   = lineLvl[0];
  assign sdaLvl   = lineLvl[1];
  assign sclRise  = lineRise[0];
  assign sclFall  = lineFall[0];
  assign startDet = lineFall[1] & sclLvl;
  assign stopDet  = lineRise[1] & sclLvl;
  assign rxNext   = {rxShift[BYTE_W-2:0], sdaLvl};
  assign txBit    = txShift[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      holdByte <= '0;
      txShift  <= '0;
      divRatio <= '0;
      ctlWord  <= '0;
    end else begin
      if (strobe.shiftIn)   rxShift  <= rxNext;
      if (strobe.holdLd)    holdByte <= rxNext;
      if (strobe.commitDiv) divRatio <= {holdByte, rxNext};
      if (strobe.commitCtl) ctlWord  <= {holdByte, rxNext};
      if (strobe.loadTx)       txShift <= statusIn;
      else if (strobe.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  // R7
  pair_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.holdLd, strobe.commitDiv, strobe.commitCtl}));

  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commitDiv |=> $stable(divRatio));

  // R7
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commitCtl |=> $stable(ctlWord));

endmodule

// File: rtl/pll_i2c_control.sv
module pll_i2c_control
  import pll_i2c_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-2:0] DEV_ADDR = 7'h61
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclLvl,
  input  logic              sdaLvl,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [BYTE_W-1:0] rxNext,
  output dpStrobe_t         strobe,
  output logic              driveAck,
  output logic              driveData
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

  busState_t        state, nState;
  logic [CNT_W-1:0] bitCnt, nBitCnt;
  logic pairOpen, nPairOpen, pairCtl, nPairCtl;
  logic isRead, nIsRead, hostAck, nHostAck;
  logic nDriveAck, nDriveData;

  always_comb begin
    nState     = state;
    nBitCnt    = bitCnt;
    nPairOpen  = pairOpen;
    nPairCtl   = pairCtl;
    nIsRead    = isRead;
    nHostAck   = hostAck;
    nDriveAck  = driveAck;
    nDriveData = driveData;
    strobe     = '0;

    if (stopDet) begin
      nState     = ST_IDLE;
      nDriveAck  = 1'b0;
      nDriveData = 1'b0;
    end else if (startDet) begin
      nState     = ST_ADDR;
      nBitCnt    = '0;
      nPairOpen  = 1'b0;
      nDriveAck  = 1'b0;
      nDriveData = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: if (sclRise) begin
          strobe.shiftIn = 1'b1;
          if (bitCnt == LAST_BIT) begin
            nBitCnt = '0;
            if (rxNext[BYTE_W-1:1] == DEV_ADDR) begin
              nIsRead = rxNext[0];
              nState  = ST_ADDR_ACK;
            end else begin
              nState  = ST_IGNORE;
            end
          end else begin
            nBitCnt = bitCnt + 1'b1;
          end
        end
        ST_ADDR_ACK, ST_WR_ACK: if (sclFall) begin
          if (!driveAck) begin
            nDriveAck = 1'b1;
          end else begin
            nDriveAck = 1'b0;
            nBitCnt   = '0;
            if (state == ST_ADDR_ACK && isRead) begin
              strobe.loadTx = 1'b1;
              nDriveData    = 1'b1;
              nState        = ST_RD_DATA;
            end else begin
              nState = ST_WR_DATA;
            end
          end
        end
        ST_WR_DATA: if (sclRise) begin
          strobe.shiftIn = 1'b1;
          if (bitCnt == LAST_BIT) begin
            nBitCnt = '0;
            nState  = ST_WR_ACK;
            if (!pairOpen) begin
              strobe.holdLd = 1'b1;
              nPairOpen     = 1'b1;
              nPairCtl      = rxNext[BYTE_W-1];
            end else begin
              strobe.commitCtl = pairCtl;
              strobe.commitDiv = ~pairCtl;
              nPairOpen        = 1'b0;
            end
          end else begin
            nBitCnt = bitCnt + 1'b1;
          end
        end
        ST_RD_DATA: begin
          if (sclRise) nBitCnt = bitCnt + 1'b1;
          else if (sclFall) begin
            if (bitCnt == ALL_BITS) begin
              nDriveData = 1'b0;
              nBitCnt    = '0;
              nState     = ST_RD_ACK;
            end else begin
              strobe.shiftTx = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) nHostAck = ~sdaLvl;
          else if (sclFall) begin
            if (hostAck) begin
              strobe.loadTx = 1'b1;
              nDriveData    = 1'b1;
              nState        = ST_RD_DATA;
            end else begin
              nState = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      pairOpen  <= 1'b0;
      pairCtl   <= 1'b0;
      isRead    <= 1'b0;
      hostAck   <= 1'b0;
      driveAck  <= 1'b0;
      driveData <= 1'b0;
    end else begin
      state     <= nState;
      bitCnt    <= nBitCnt;
      pairOpen  <= nPairOpen;
      pairCtl   <= nPairCtl;
      isRead    <= nIsRead;
      hostAck   <= nHostAck;
      driveAck  <= nDriveAck;
      driveData <= nDriveData;
    end
  end

  // R12
  shift_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftIn |-> sclRise);

  // R10
  load_while_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTx |-> !sclLvl);

  // R2
  ack_slot_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveAck |-> (state == ST_ADDR_ACK || state == ST_WR_ACK));

  // R3
  ignore_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> !(driveAck || driveData));

endmodule

// File: rtl/pll_i2c_slave.sv
module pll_i2c_slave
  import pll_i2c_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter logic [BYTE_W-2:0] DEV_ADDR = 7'h61,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  logic [BYTE_W-1:0]   statusIn,
  output logic                sdaPullLow,
  output logic [2*BYTE_W-1:0] divRatio,
  output logic [2*BYTE_W-1:0] ctlWord
);
  dpStrobe_t         strobe;
  logic              sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic              txBit, driveAck, driveData;
  logic [BYTE_W-1:0] rxNext;

  pll_i2c_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_TAPS  (FILT_TAPS),
    .BYTE_W     (BYTE_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .statusIn(statusIn), .strobe(strobe),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .rxNext(rxNext), .txBit(txBit),
    .divRatio(divRatio), .ctlWord(ctlWord)
  );

  pll_i2c_control #(
    .BYTE_W  (BYTE_W),
    .DEV_ADDR(DEV_ADDR)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sdaLvl(sdaLvl),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .rxNext(rxNext), .strobe(strobe),
    .driveAck(driveAck), .driveData(driveData)
  );

  assign sdaPullLow = driveAck | (driveData & ~txBit);

  // R9
  sda_moves_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclLvl);

endmodule

// File: tb/pll_i2c_slave_tb.sv
module pll_i2c_slave_tb_top;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic [7:0]  statusIn = 8'h00;
  logic        sdaPullLow;
  logic [15:0] divRatio, ctlWord;
  wire         sdaBus = mSda & ~sdaPullLow;

  int checkCount = 0;
  int failCount  = 0;

  always #2 clk = ~clk;

  pll_i2c_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus),
    .statusIn(statusIn), .sdaPullLow(sdaPullLow),
    .divRatio(divRatio), .ctlWord(ctlWord)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitQ(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic startCond();
    mSda = 1'b1; mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic repStart();
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    mSda = 1'b0; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b1; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ackN,
                           input bit glitch = 1'b0);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i];
      if (glitch && i == 4) begin
        repeat (Q / 2) @(negedge clk);
        mScl = 1'b1; @(negedge clk);
        mScl = 1'b0;
        repeat (Q / 2 - 1) @(negedge clk);
      end else begin
        waitQ();
      end
      mScl = 1'b1; waitQ(2);
      mScl = 1'b0; waitQ();
    end
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    ackN = sdaBus;
    waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic readByte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mSda = 1'b1; waitQ();
      mScl = 1'b1; waitQ();
      b[i] = sdaBus;
      waitQ();
      mScl = 1'b0; waitQ();
    end
  endtask

  task automatic hostAck(input bit ack);
    mSda = ack ? 1'b0 : 1'b1; waitQ();
    mScl = 1'b1; waitQ(2);
    mScl = 1'b0;
    mSda = 1'b1; waitQ();
  endtask

  task automatic testReset();
    check(sdaPullLow == 1'b0, "R1 sda released", 32'(sdaPullLow), 0);
    check(divRatio == 16'h0, "R1 divider", 32'(divRatio), 0);
    check(ctlWord == 16'h0, "R1 control", 32'(ctlWord), 0);
  endtask

  task automatic testDivider();
    logic a;
    startCond();
    writeByte(8'hC2, a); check(a == 1'b0, "R2 address ack", 32'(a), 0);
    writeByte(8'h12, a); check(a == 1'b0, "R8 data ack", 32'(a), 0);
    check(divRatio == 16'h0, "R7 no update after first byte", 32'(divRatio), 0);
    writeByte(8'h34, a); check(a == 1'b0, "R8 data ack 2", 32'(a), 0);
    check(divRatio == 16'h1234, "R4 divider pair", 32'(divRatio), 32'h1234);
    check(ctlWord == 16'h0, "R4 control untouched", 32'(ctlWord), 0);
    stopCond();
  endtask

  task automatic testControl();
    logic a;
    startCond();
    writeByte(8'hC2, a);
    writeByte(8'h86, a);
    check(ctlWord == 16'h0, "R7 control waits for pair", 32'(ctlWord), 0);
    writeByte(8'h55, a);
    check(ctlWord == 16'h8655, "R5 control pair", 32'(ctlWord), 32'h8655);
    stopCond();
  endtask

  task automatic testMixed();
    logic a;
    startCond();
    writeByte(8'hC2, a);
    writeByte(8'hC1, a); writeByte(8'h02, a);
    writeByte(8'h07, a); writeByte(8'h89, a);
    check(ctlWord == 16'hC102, "R6 control first", 32'(ctlWord), 32'hC102);
    check(divRatio == 16'h0789, "R6 divider third byte", 32'(divRatio), 32'h0789);
    stopCond();
  endtask

  task automatic testMismatch();
    logic a;
    startCond();
    writeByte(8'hC4, a); check(a == 1'b1, "R3 no ack on mismatch", 32'(a), 1);
    writeByte(8'h00, a); check(a == 1'b1, "R3 no ack after mismatch", 32'(a), 1);
    writeByte(8'h00, a);
    check(divRatio == 16'h0789, "R3 divider unchanged", 32'(divRatio), 32'h0789);
    stopCond();
    writeByte(8'hC2, a); check(a == 1'b1, "R3 ignored without start", 32'(a), 1);
    stopCond();
  endtask

  task automatic testRead();
    logic a;
    logic [7:0] d;
    bit released = 1'b1;
    statusIn = 8'hA5;
    startCond();
    writeByte(8'hC3, a); check(a == 1'b0, "R2 read address ack", 32'(a), 0);
    readByte(d); check(d == 8'hA5, "R9 status byte", 32'(d), 32'hA5);
    statusIn = 8'h3C;
    hostAck(1'b1);
    readByte(d); check(d == 8'h3C, "R10 repeated status", 32'(d), 32'h3C);
    hostAck(1'b0);
    mScl = 1'b1;
    for (int i = 0; i < 2 * Q; i++) begin
      @(negedge clk);
      if (sdaPullLow) released = 1'b0;
    end
    mScl = 1'b0; waitQ();
    check(released, "R10 released after nack", 32'(released), 1);
    stopCond();
  endtask

  task automatic testRepStart();
    logic a;
    startCond();
    writeByte(8'hC2, a);
    writeByte(8'h11, a);
    repStart();
    writeByte(8'hC2, a); check(a == 1'b0, "R11 address after repeated start", 32'(a), 0);
    writeByte(8'h9A, a); writeByte(8'hBC, a);
    check(ctlWord == 16'h9ABC, "R11 new pair", 32'(ctlWord), 32'h9ABC);
    check(divRatio == 16'h0789, "R7 half pair dropped", 32'(divRatio), 32'h0789);
    stopCond();
  endtask

  task automatic testGlitch();
    logic a;
    startCond();
    writeByte(8'hC2, a);
    writeByte(8'h2B, a, 1'b1);
    check(a == 1'b0, "R12 ack despite glitch", 32'(a), 0);
    writeByte(8'h4D, a);
    check(divRatio == 16'h2B4D, "R12 glitch ignored", 32'(divRatio), 32'h2B4D);
    stopCond();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    testReset();
    rstN = 1'b1;
    waitQ();
    testReset();
    testDivider();
    testControl();
    testMixed();
    testMismatch();
    testRead();
    testRepStart();
    testGlitch();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule